// File: doc/BRIEF.md
# Six-Stage Pipeline Hazard Control Unit

This block is the purely combinational hazard and bypass controller for an in-order six-stage integer pipeline (fetch, decode, execute, two data-memory stages M1 and M2, write-back). Data memory needs two cycles, so every load or store holds M1 and then M2. The unit sits beside the decode stage. It compares the decode instruction's source registers against the destination registers of the four stages in front of it. It then chooses a bypass source for each operand and decides whether decode must wait.

The register file is written only at the end of write-back, so the write-back stage is a bypass source like the others. A load's data exists only at the end of M2. A consumer therefore waits in decode while the load is in EX or M1. Two memory operations back to back also wait one cycle, so that they do not share M1/M2. Stall requests are dropped when the execute stage is redirecting the front end, because the decode instruction is being discarded anyway. All pins are plain control signals. There is no streaming interface and no back-pressure protocol.

Top module: `hz_unit6`

## Requirements
- R1: For each operand, the bypass select names the youngest matching writer. Priority runs EX, then M1, then M2, then WB, then the register file. The encodings are register file = 0, EX = 1, M1 = 2, M2 = 3, WB = 4.
- R2: A stage counts as a writer only when its valid and write-enable are both high and its destination is not register 0. A source of register 0 always selects the register file and never causes a stall.
- R3: An operand whose use flag is low selects the register file and never causes a stall.
- R4: When the youngest matching writer is a load in EX or in M1, decode stalls.
- R5: When the youngest matching writer is a load in M2 or WB, the value is bypassed from that stage and decode does not stall.
- R6: When a younger non-load writer in EX or M1 targets the same register as an older load in M1, the younger writer is selected and no load stall results.
- R7: A valid memory operation in decode stalls when EX holds a valid memory operation, regardless of the registers involved.
- R8: A stall drives the PC hold, the fetch/decode hold and the execute bubble high together. With no stall, all three are low.
- R9: When the redirect input is high, no stall is raised.
- R10: When decode is not valid, no stall is raised.
- R11: A load followed directly by a store of the loaded register costs exactly two stall cycles. The store then takes its data from M2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | REG_AW | First source register in decode |
| id_rs2 | input | REG_AW | Second source register in decode |
| id_use_rs1 | input | 1 | Decode instruction reads the first source |
| id_use_rs2 | input | 1 | Decode instruction reads the second source |
| id_is_mem | input | 1 | Decode instruction is a load or store |
| ex_valid | input | 1 | EX stage holds a real instruction |
| ex_rd | input | REG_AW | EX destination register |
| ex_wen | input | 1 | EX writes its destination |
| ex_is_load | input | 1 | EX instruction is a load |
| ex_is_mem | input | 1 | EX instruction is a load or store |
| m1_valid | input | 1 | M1 stage holds a real instruction |
| m1_rd | input | REG_AW | M1 destination register |
| m1_wen | input | 1 | M1 writes its destination |
| m1_is_load | input | 1 | M1 instruction is a load |
| m2_valid | input | 1 | M2 stage holds a real instruction |
| m2_rd | input | REG_AW | M2 destination register |
| m2_wen | input | 1 | M2 writes its destination |
| wb_valid | input | 1 | WB stage holds a real instruction |
| wb_rd | input | REG_AW | WB destination register |
| wb_wen | input | 1 | WB writes its destination |
| ex_redirect | input | 1 | Misprediction redirect from EX, flushing decode |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| ex_bubble | output | 1 | Inject an empty slot into EX |
| fwd_a | output | 3 | Bypass select for the first operand |
| fwd_b | output | 3 | Bypass select for the second operand |

## Verification
The bench builds the unit with its default register address width of 5, which covers all 32 architectural registers. The random stimulus draws source and destination registers from only registers 0 to 3. Register collisions across several stages are therefore frequent. This brings within reach the priority shadowing between stages, bypass attempts on register 0, and loads hidden behind younger writers. Directed cases walk a load-then-store pair through three consecutive pipeline snapshots to count its stall cycles.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NSTG = 4;  // EX, M1, M2, WB, youngest first

  typedef enum logic [2:0] {
    FWD_RF = 3'd0,
    FWD_EX = 3'd1,
    FWD_M1 = 3'd2,
    FWD_M2 = 3'd3,
    FWD_WB = 3'd4
  } fwd_sel_e;

  // stages whose load data is not yet available to decode
  localparam logic [NSTG-1:0] LOAD_PENDING = 4'b0011;
endpackage

// File: rtl/hz_writer_match.sv
module hz_writer_match
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0]            src,
  input  logic                         src_used,
  input  logic [NSTG-1:0]              wr_valid,
  input  logic [NSTG-1:0]              wr_wen,
  input  logic [NSTG-1:0][REG_AW-1:0]  wr_rd,
  output logic [NSTG-1:0]              hit
);
  logic src_live;
  assign src_live = src_used && (src != '0);

  for (genvar s = 0; s < NSTG; s++) begin : g_cmp
    assign hit[s] = src_live && wr_valid[s] && wr_wen[s] && (wr_rd[s] == src);
  end
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
(
  input  logic [NSTG-1:0] hit,
  input  logic [NSTG-1:0] is_load,
  output fwd_sel_e        sel,
  output logic            load_block
);
  always_comb begin
    sel        = FWD_RF;
    load_block = 1'b0;
    // walk from the oldest stage so the youngest hit is written last
    for (int s = NSTG - 1; s >= 0; s--) begin
      if (hit[s]) begin
        sel        = fwd_sel_e'(3'(s + 1));
        load_block = is_load[s] && LOAD_PENDING[s];
      end
    end
  end
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl (
  input  logic id_valid,
  input  logic id_is_mem,
  input  logic ex_valid,
  input  logic ex_is_mem,
  input  logic block_a,
  input  logic block_b,
  input  logic redirect,
  output logic stall
);
  logic port_busy;
  assign port_busy = id_is_mem && ex_valid && ex_is_mem;
  assign stall = id_valid && !redirect && (block_a || block_b || port_busy);
endmodule

// File: rtl/hz_unit6.sv
module hz_unit6
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_use_rs1,
  input  logic              id_use_rs2,
  input  logic              id_is_mem,
  input  logic              ex_valid,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic              ex_is_mem,
  input  logic              m1_valid,
  input  logic [REG_AW-1:0] m1_rd,
  input  logic              m1_wen,
  input  logic              m1_is_load,
  input  logic              m2_valid,
  input  logic [REG_AW-1:0] m2_rd,
  input  logic              m2_wen,
  input  logic              wb_valid,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  input  logic              ex_redirect,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              ex_bubble,
  output logic [2:0]        fwd_a,
  output logic [2:0]        fwd_b
);
  localparam int NOPS = 2;

  logic [NSTG-1:0]             wr_valid, wr_wen, wr_load;
  logic [NSTG-1:0][REG_AW-1:0] wr_rd;

  assign wr_valid = {wb_valid, m2_valid, m1_valid, ex_valid};
  assign wr_wen   = {wb_wen, m2_wen, m1_wen, ex_wen};
  assign wr_load  = {1'b0, 1'b0, m1_is_load, ex_is_load};
  assign wr_rd    = {wb_rd, m2_rd, m1_rd, ex_rd};

  logic [NOPS-1:0][REG_AW-1:0] src;
  logic [NOPS-1:0]             src_used;
  logic [NOPS-1:0]             block;
  fwd_sel_e                    sel [NOPS];

  assign src      = {id_rs2, id_rs1};
  assign src_used = {id_use_rs2, id_use_rs1};

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    logic [NSTG-1:0] hit;

    hz_writer_match #(.REG_AW(REG_AW)) u_match (
      .src      (src[k]),
      .src_used (src_used[k]),
      .wr_valid (wr_valid),
      .wr_wen   (wr_wen),
      .wr_rd    (wr_rd),
      .hit      (hit)
    );

    hz_fwd_pick u_pick (
      .hit        (hit),
      .is_load    (wr_load),
      .sel        (sel[k]),
      .load_block (block[k])
    );
  end

  logic stall;

  hz_stall_ctl u_stall (
    .id_valid  (id_valid),
    .id_is_mem (id_is_mem),
    .ex_valid  (ex_valid),
    .ex_is_mem (ex_is_mem),
    .block_a   (block[0]),
    .block_b   (block[1]),
    .redirect  (ex_redirect),
    .stall     (stall)
  );

  assign pc_hold   = stall;
  assign ifid_hold = stall;
  assign ex_bubble = stall;
  assign fwd_a     = sel[0];
  assign fwd_b     = sel[1];
endmodule

// File: rtl/hz_unit6_chk.sv
module hz_unit6_chk #(
  parameter int REG_AW = 5
) (
  input logic              id_valid,
  input logic [REG_AW-1:0] id_rs1,
  input logic              id_use_rs1,
  input logic              id_is_mem,
  input logic              ex_valid,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_wen,
  input logic              ex_is_mem,
  input logic              ex_redirect,
  input logic              pc_hold,
  input logic              ifid_hold,
  input logic              ex_bubble,
  input logic [2:0]        fwd_a,
  input logic [2:0]        fwd_b
);
  always_comb begin
    AST_HOLD_TRIO: assert (pc_hold == ifid_hold && ifid_hold == ex_bubble); // R8
    AST_FLUSH_NO_STALL: assert (!ex_redirect || !pc_hold); // R9
    AST_IDLE_NO_STALL: assert (id_valid || !pc_hold); // R10
    AST_ZERO_SRC_RF: assert (id_rs1 != '0 || fwd_a == 3'd0); // R2
    AST_UNUSED_SRC_RF: assert (id_use_rs1 || fwd_a == 3'd0); // R3
    AST_EX_SEL_MATCH: assert (fwd_a != 3'd1 || (ex_valid && ex_wen && ex_rd == id_rs1)); // R1
    AST_SEL_RANGE: assert (fwd_a <= 3'd4 && fwd_b <= 3'd4); // R1
    AST_PORT_CONFLICT: assert (!(id_valid && id_is_mem && ex_valid && ex_is_mem && !ex_redirect) || pc_hold); // R7
  end
endmodule

bind hz_unit6 hz_unit6_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/hz_unit6_tb.sv
module hz_unit6_tb;
  localparam int AW = 5;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND = 3000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          id_valid, id_use_rs1, id_use_rs2, id_is_mem, ex_is_mem, ex_redirect;
  logic [AW-1:0] id_rs1, id_rs2;
  logic          sv_v [4], sv_w [4], sv_ld [4];
  logic [AW-1:0] sv_rd [4];

  logic       pc_hold, ifid_hold, ex_bubble;
  logic [2:0] fwd_a, fwd_b;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  hz_unit6 #(.REG_AW(AW)) u_dut (
    .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .id_is_mem(id_is_mem),
    .ex_valid(sv_v[0]), .ex_rd(sv_rd[0]), .ex_wen(sv_w[0]),
    .ex_is_load(sv_ld[0]), .ex_is_mem(ex_is_mem),
    .m1_valid(sv_v[1]), .m1_rd(sv_rd[1]), .m1_wen(sv_w[1]), .m1_is_load(sv_ld[1]),
    .m2_valid(sv_v[2]), .m2_rd(sv_rd[2]), .m2_wen(sv_w[2]),
    .wb_valid(sv_v[3]), .wb_rd(sv_rd[3]), .wb_wen(sv_w[3]),
    .ex_redirect(ex_redirect),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .ex_bubble(ex_bubble),
    .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  // expected select: 0 register file, 1 EX, 2 M1, 3 M2, 4 WB
  function automatic logic [2:0] ref_sel(input logic [AW-1:0] rs, input logic used);
    if (!used || rs == '0) return 3'd0;
    for (int s = 0; s < 4; s++)
      if (sv_v[s] && sv_w[s] && sv_rd[s] == rs) return 3'(s + 1);
    return 3'd0;
  endfunction

  function automatic logic ref_block(input logic [AW-1:0] rs, input logic used);
    if (!used || rs == '0) return 1'b0;
    for (int s = 0; s < 4; s++)
      if (sv_v[s] && sv_w[s] && sv_rd[s] == rs) return (s < 2) && sv_ld[s];
    return 1'b0;
  endfunction

  function automatic logic ref_stall();
    return id_valid && !ex_redirect &&
           (ref_block(id_rs1, id_use_rs1) || ref_block(id_rs2, id_use_rs2) ||
            (id_is_mem && sv_v[0] && ex_is_mem));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    id_valid = 0; id_rs1 = 0; id_rs2 = 0; id_use_rs1 = 0; id_use_rs2 = 0;
    id_is_mem = 0; ex_is_mem = 0; ex_redirect = 0;
    for (int s = 0; s < 4; s++) begin
      sv_v[s] = 0; sv_w[s] = 0; sv_ld[s] = 0; sv_rd[s] = 0;
    end
  endtask

  task automatic put(input int s, input int rd, input logic ld);
    sv_v[s] = 1; sv_w[s] = 1; sv_rd[s] = AW'(rd); sv_ld[s] = ld;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic full_check(input string tag);
    logic st;
    st = ref_stall();
    chk(tag, "fwd_a", int'(fwd_a), int'(ref_sel(id_rs1, id_use_rs1)));
    chk(tag, "fwd_b", int'(fwd_b), int'(ref_sel(id_rs2, id_use_rs2)));
    chk(tag, "pc_hold", int'(pc_hold), int'(st));
    chk("R8", "ifid_hold", int'(ifid_hold), int'(st));
    chk("R8", "ex_bubble", int'(ex_bubble), int'(st));
  endtask

  initial begin
    int stalls;
    void'($urandom(32'h5EED_0C06));
    clear_all();
    settle();
    chk("R10", "reset pc_hold", int'(pc_hold), 0);
    chk("R1", "reset fwd_a", int'(fwd_a), 0);

    // R1 priority: every stage writes r3, EX wins, then M1 after EX removed
    clear_all(); id_valid = 1; id_rs1 = 3; id_use_rs1 = 1;
    for (int s = 0; s < 4; s++) put(s, 3, 0);
    settle(); chk("R1", "EX priority", int'(fwd_a), 1);
    sv_v[0] = 0; settle(); chk("R1", "M1 priority", int'(fwd_a), 2);
    sv_v[1] = 0; settle(); chk("R1", "M2 priority", int'(fwd_a), 3);
    sv_v[2] = 0; settle(); chk("R1", "WB bypass", int'(fwd_a), 4);

    // R2 register 0 never bypassed or stalled, even behind a load in EX
    clear_all(); id_valid = 1; id_use_rs1 = 1; put(0, 0, 1);
    settle(); chk("R2", "x0 sel", int'(fwd_a), 0); chk("R2", "x0 stall", int'(pc_hold), 0);

    // R3 unused operand ignored
    clear_all(); id_valid = 1; id_rs2 = 4; id_use_rs2 = 0; put(0, 4, 1);
    settle(); chk("R3", "unused sel", int'(fwd_b), 0); chk("R3", "unused stall", int'(pc_hold), 0);

    // R4 load in EX, then in M1
    clear_all(); id_valid = 1; id_rs2 = 6; id_use_rs2 = 1; put(0, 6, 1);
    settle(); chk("R4", "load EX stall", int'(pc_hold), 1);
    clear_all(); id_valid = 1; id_rs2 = 6; id_use_rs2 = 1; put(1, 6, 1);
    settle(); chk("R4", "load M1 stall", int'(pc_hold), 1);

    // R5 load in M2 / WB bypassed
    clear_all(); id_valid = 1; id_rs1 = 7; id_use_rs1 = 1; put(2, 7, 0);
    settle(); chk("R5", "load M2 stall", int'(pc_hold), 0); chk("R5", "load M2 sel", int'(fwd_a), 3);

    // R6 younger ALU write in EX hides load in M1
    clear_all(); id_valid = 1; id_rs1 = 9; id_use_rs1 = 1; put(0, 9, 0); put(1, 9, 1);
    settle(); chk("R6", "shadow stall", int'(pc_hold), 0); chk("R6", "shadow sel", int'(fwd_a), 1);

    // R7 structural: store after store with unrelated registers
    clear_all(); id_valid = 1; id_is_mem = 1; sv_v[0] = 1; ex_is_mem = 1;
    settle(); chk("R7", "mem port stall", int'(pc_hold), 1);

    // R9 redirect suppresses
    ex_redirect = 1; settle(); chk("R9", "redirect stall", int'(pc_hold), 0);

    // R10 invalid decode
    clear_all(); id_rs1 = 6; id_use_rs1 = 1; put(0, 6, 1);
    settle(); chk("R10", "idle stall", int'(pc_hold), 0);

    // R11 load r5 then store of r5: three pipeline snapshots
    stalls = 0;
    clear_all(); id_valid = 1; id_is_mem = 1; id_rs1 = 8; id_rs2 = 5;
    id_use_rs1 = 1; id_use_rs2 = 1; put(0, 5, 1); ex_is_mem = 1;
    settle(); stalls += int'(pc_hold);
    sv_v[0] = 0; sv_w[0] = 0; sv_ld[0] = 0; ex_is_mem = 0; put(1, 5, 1);
    settle(); stalls += int'(pc_hold);
    sv_v[1] = 0; sv_w[1] = 0; put(2, 5, 0);
    settle(); stalls += int'(pc_hold);
    chk("R11", "lw-sw stall cycles", stalls, 2);
    chk("R11", "store data sel", int'(fwd_b), 3);

    // random mix
    for (int i = 0; i < N_RAND; i++) begin
      id_valid    = ($urandom % 8) != 0;
      id_rs1      = AW'($urandom % 4);
      id_rs2      = AW'($urandom % 4);
      id_use_rs1  = ($urandom % 4) != 0;
      id_use_rs2  = ($urandom % 2) != 0;
      id_is_mem   = ($urandom % 3) == 0;
      ex_redirect = ($urandom % 10) == 0;
      for (int s = 0; s < 4; s++) begin
        sv_v[s]  = ($urandom % 4) != 0;
        sv_w[s]  = ($urandom % 3) != 0;
        sv_rd[s] = AW'($urandom % 4);
        sv_ld[s] = (s < 2) && (($urandom % 3) == 0);
      end
      ex_is_mem = sv_ld[0] || (($urandom % 4) == 0);
      settle();
      full_check("R1/R4/R7");
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule